// File: doc/BRIEF.md
# BCD Decade Counter with Nine-Detect Reload

This block is a synchronous binary counter with a count enable and a parallel load. It is turned into a decade counter by a reload path. A small decoder looks at the running value. When the value reaches nine while counting is enabled, the decoder asserts the load and the register takes zero at the next clock edge. The decoder looks only at the bits that are set in the terminal value, which are bit 3 and bit 0 for nine. A full equality compare is not used.

An external load request can also seed the register with any value. That request is ORed into the same load path and has priority over both counting and the internal wrap. If the seeded value is above nine, the counter must find its way back into the decade range. A terminal-count output flags the last count of the decade while counting is enabled. With the default parameters the register is 4 bits wide and the terminal value is nine.

Top module: `decade_reload_ctr`

## Requirements
- R1: A high `rst` at a clock edge sets `count` to 0000 at that edge. It takes priority over every other input.
- R2: With `ld_ext` low and `cnt_en` low, `count` keeps its value across the edge. This holds at every value, including 1001.
- R3: With `ld_ext` low and `cnt_en` high, a value that does not have both bit 3 and bit 0 set advances by one at the edge.
- R4: With `cnt_en` high and `ld_ext` low, 1001 is followed by 0000.
- R5: A high `ld_ext` places `ld_val` in `count` at the edge. This happens whatever the level of `cnt_en` and whatever the current value, including 1001.
- R6: `tc` is high exactly while `count` is 1001 and `cnt_en` is high.
- R7: With counting enabled and no external load, a seeded value with bit 3 and bit 0 both set (1011, 1101, 1111) reloads to 0000 at the next edge. The values 1010, 1100 and 1110 first step to 1011, 1101 and 1111, so every out-of-range value returns to 0000 within two edges.
- R8: Starting from 0000 with `cnt_en` held high and no load, the counter passes through 0 to 9 in order and returns to 0000 after exactly ten edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| ld_ext | input | 1 | External load request |
| ld_val | input | 4 | Value taken on an external load |
| count | output | 4 | Current counter value |
| tc | output | 1 | Terminal count: value is nine and counting is enabled |

## Verification
The properties assume that the control inputs are settled at every rising edge. They also assume that `ld_val` may hold any of the sixteen codes, including those above nine, so the recovery property sees real out-of-range states. The stimulus meets these assumptions in two ways. It drives every input on the falling edge. Its random mix of loads draws the full 4-bit range, with the enable high most of the time so that wraps and recoveries happen often. Directed sequences force the corners: a hold at nine, a load at nine, a load with the enable low, and each of the six out-of-range seeds.

// File: rtl/decade_pkg.sv
package decade_pkg;

   typedef enum logic [0:0] {
      DET_SPARSE = 1'b0,
      DET_FULL   = 1'b1
   } detect_e;

   // True when no value below term carries every bit that is set in term,
   // so that a decoder of only those bits cannot fire early.
   function automatic bit sparse_safe(input int unsigned term);
      for (int unsigned v = 0; v < term; v++) begin
         if ((v & term) == term) return 1'b0;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/dc_load_reg.sv
module dc_load_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             inc,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
      else if (inc)  q <= q + STEP;
   end

endmodule

// File: rtl/dc_term_detect.sv
module dc_term_detect #(
   parameter int                  WIDTH  = 4,
   parameter int unsigned         TERM   = 9,
   parameter decade_pkg::detect_e DETECT = decade_pkg::DET_SPARSE
) (
   input  logic [WIDTH-1:0] q,
   output logic             hit
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

   generate
      if (DETECT == decade_pkg::DET_SPARSE) begin : g_sparse
         // AND of the bit positions that are one in the terminal value
         assign hit = &(q | ~TERM_V);
      end else begin : g_full
         assign hit = (q == TERM_V);
      end
   endgenerate

endmodule

// File: rtl/dc_load_sel.sv
module dc_load_sel #(
   parameter int          WIDTH  = 4,
   parameter int unsigned RELOAD = 0
) (
   input  logic             ext_ld,
   input  logic [WIDTH-1:0] ext_d,
   input  logic             wrap_ld,
   output logic             load,
   output logic [WIDTH-1:0] d
);

   localparam logic [WIDTH-1:0] RELOAD_V = WIDTH'(RELOAD);

   assign load = ext_ld | wrap_ld;
   assign d    = ext_ld ? ext_d : RELOAD_V;

endmodule

// File: rtl/decade_reload_ctr.sv
module decade_reload_ctr #(
   parameter int                  WIDTH  = 4,
   parameter int unsigned         TERM   = 9,
   parameter decade_pkg::detect_e DETECT = decade_pkg::DET_SPARSE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             ld_ext,
   input  logic [WIDTH-1:0] ld_val,
   output logic [WIDTH-1:0] count,
   output logic             tc
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);

   if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
      $error("decade_reload_ctr: WIDTH out of range");
   end
   if (TERM == 0 || TERM >= (1 << WIDTH)) begin : g_bad_term
      $error("decade_reload_ctr: TERM must be nonzero and fit in WIDTH");
   end
   if (DETECT == decade_pkg::DET_SPARSE && !decade_pkg::sparse_safe(TERM)) begin : g_bad_sparse
      $error("decade_reload_ctr: TERM bits appear in a smaller value");
   end

   logic             hit;
   logic             wrap_ld;
   logic             load;
   logic [WIDTH-1:0] d;

   dc_term_detect #(.WIDTH(WIDTH), .TERM(TERM), .DETECT(DETECT)) u_det (
      .q   (count),
      .hit (hit)
   );

   assign wrap_ld = cnt_en & hit;

   dc_load_sel #(.WIDTH(WIDTH), .RELOAD(0)) u_sel (
      .ext_ld  (ld_ext),
      .ext_d   (ld_val),
      .wrap_ld (wrap_ld),
      .load    (load),
      .d       (d)
   );

   dc_load_reg #(.WIDTH(WIDTH)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .inc  (cnt_en),
      .d    (d),
      .q    (count)
   );

   assign tc = cnt_en & (count == TERM_V);

endmodule

// File: rtl/decade_reload_ctr_chk.sv
module decade_reload_ctr_chk #(
   parameter int                  WIDTH  = 4,
   parameter int unsigned         TERM   = 9,
   parameter decade_pkg::detect_e DETECT = decade_pkg::DET_SPARSE
) (
   input logic             clk,
   input logic             rst,
   input logic             cnt_en,
   input logic             ld_ext,
   input logic [WIDTH-1:0] ld_val,
   input logic [WIDTH-1:0] count,
   input logic             tc
);

   localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);
   localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

   AST_RESET_ZERO: assert property (@(posedge clk) rst |=> count == '0); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!ld_ext && !cnt_en) |=> count == $past(count)); // R2
   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (!ld_ext && cnt_en && ((count & TERM_V) != TERM_V)) |=> count == $past(count) + ONE); // R3
   AST_WRAP_NINE: assert property (@(posedge clk) disable iff (rst)
      (!ld_ext && cnt_en && count == TERM_V) |=> count == '0); // R4
   AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
      ld_ext |=> count == $past(ld_val)); // R5
   AST_TC_NEXT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (tc && !ld_ext) |=> count == '0); // R6
   AST_TC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      tc |-> cnt_en); // R6

   if (DETECT == decade_pkg::DET_SPARSE) begin : g_sparse_chk
      AST_RECOVER: assert property (@(posedge clk) disable iff (rst)
         (!ld_ext && cnt_en && ((count & TERM_V) == TERM_V)) |=> count == '0); // R7
   end

endmodule

bind decade_reload_ctr decade_reload_ctr_chk #(
   .WIDTH(WIDTH), .TERM(TERM), .DETECT(DETECT)
) u_chk (
   .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_ext(ld_ext),
   .ld_val(ld_val), .count(count), .tc(tc)
);

// File: tb/decade_reload_ctr_tb.sv
module decade_reload_ctr_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cnt_en = 1'b0;
   logic       ld_ext = 1'b0;
   logic [3:0] ld_val = 4'd0;
   logic [3:0] count;
   logic       tc;

   int n_run  = 0;
   int n_fail = 0;
   logic [3:0] exp_q = 4'd0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 4 ns period

   decade_reload_ctr u_dut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_ext(ld_ext),
      .ld_val(ld_val), .count(count), .tc(tc)
   );

   // Next value from the requirements
   function automatic logic [3:0] model_next(logic [3:0] q, logic r, logic en,
                                             logic ld, logic [3:0] d);
      if (r)                    return 4'd0;    // R1
      if (ld)                   return d;       // R5
      if (!en)                  return q;       // R2
      if (q[3] && q[0])         return 4'd0;    // R4, R7
      return q + 4'd1;                          // R3
   endfunction

   function automatic string tag_of(logic [3:0] q, logic r, logic en, logic ld);
      if (r)                return "R1";
      if (ld)               return "R5";
      if (!en)              return "R2";
      if (q == 4'd9)        return "R4";
      if (q > 4'd9)         return "R7";
      return "R3";
   endfunction

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock: drive on the falling edge, check tc, then check count after the edge
   task automatic step(logic r, logic en, logic ld, logic [3:0] d);
      string t;
      @(negedge clk);
      rst = r; cnt_en = en; ld_ext = ld; ld_val = d;
      #1;
      if (!r) check("R6", {3'b0, tc}, {3'b0, en && exp_q == 4'd9});
      t = tag_of(exp_q, r, en, ld);
      exp_q = model_next(exp_q, r, en, ld, d);
      @(posedge clk);
      #1;
      check(t, count, exp_q);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      step(1'b1, 1'b0, 1'b0, 4'd0);
      step(1'b1, 1'b1, 1'b1, 4'd7);           // R1 wins over load
      // R8: full decade, ten edges back to zero
      begin
         int edges = 0;
         do begin
            step(1'b0, 1'b1, 1'b0, 4'd0);
            edges++;
         end while (count != 4'd0 && edges < 20);
         check("R8", 4'(edges), 4'd10);
      end
      // R2: hold at nine with enable low
      for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 1'b0, 4'd0);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 4'd0);
      check("R2", count, 4'd9);
      step(1'b0, 1'b0, 1'b1, 4'd5);           // R5 load at nine, enable low
      step(1'b0, 1'b1, 1'b1, 4'd9);
      step(1'b0, 1'b1, 1'b1, 4'd3);           // R5 load at nine over wrap
      // R7: each out-of-range seed
      for (int s = 10; s < 16; s++) begin
         step(1'b0, 1'b1, 1'b1, 4'(s));
         step(1'b0, 1'b1, 1'b0, 4'd0);
         if (count != 4'd0) step(1'b0, 1'b1, 1'b0, 4'd0);
         check("R7", count, 4'd0);
      end
      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic r, en, ld;
         r  = ($urandom % 100) < 1;
         en = ($urandom % 100) < 80;
         ld = ($urandom % 100) < 6;
         step(r, en, ld, 4'($urandom));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule